// File: doc/BRIEF.md
# Range-Axis Adaptive Threshold Detector (CA / GO / SO)

This block decides, cell by cell along the range axis of one Doppler column, whether a return stands out from its local noise floor. Each incoming complex sample is reduced to an L1 magnitude and stored. Once a full column is held, a scan walks the cells in ascending range order. For each cell under test it keeps two running noise estimates, one on the near side and one on the far side, with a configurable number of guard cells skipped next to the cell.

The two estimates are merged according to a selectable rule: the plain sum (cell averaging), the larger side (greatest-of) or the smaller side (smallest-of). Greatest-of and smallest-of compare the per-cell averages without a divider by cross-multiplying each sum with the opposite side's cell count. The merged value is scaled by an unsigned fixed-point gain with four fraction bits and clipped to 17 bits, which gives the threshold. Each result carries the cell index, the detect flag, the magnitude and the threshold.

A column is loaded as `NCELL` consecutive accepted samples. While the scan runs, `busy` is high and any offered samples are dropped, so the upstream producer waits for `busy` to fall before it starts the next column. Typical settings are guard 2, train 8 and gain 0x30 (3.0).

Top module: `cfar_detector`

## Requirements
- R1: The magnitude of a cell is |I| + |Q|. Each absolute value is taken as a 16-bit unsigned result, so an input of -32768 contributes 32768, and the 17-bit sum is reported on `out_mag`.
- R2: For cell c with guard g and train t, the near window holds the cells c-g-t to c-g-1 and the far window holds c+g+1 to c+g+t. Cells outside 0 to NCELL-1 are left out, and each side counts only the cells it actually uses.
- R3: With mode 0 (cell averaging), the noise value is the near sum plus the far sum.
- R4: With mode 1 (greatest-of), the near sum is taken when near_sum × far_count > far_sum × near_count, and the far sum otherwise. When one side has no cells, the other side's sum is used.
- R5: With mode 2 (smallest-of), the rule of R4 applies with "<" in place of ">", including the same empty-side fallback.
- R6: The threshold is (gain × noise) shifted right by 4 and clipped to 131071. It is reported on `out_thr`.
- R7: `out_detect` is 1 exactly when the magnitude is strictly greater than the threshold. A magnitude equal to the threshold is not a detection.
- R8: The mode field is decoded as 0 = cell averaging, 1 = greatest-of, 2 = smallest-of, and 3 = cell averaging.
- R9: A train setting of 0 is handled as a train of 1.
- R10: A sample is accepted when `in_valid` is high and `busy` is low. After the NCELL-th accepted sample, the guard, train, gain and mode inputs are captured and `busy` rises. `busy` stays high until the last result has been issued. Samples offered while `busy` is high are not stored, and configuration changes during the scan have no effect on it. After reset, `busy` and `out_valid` are low.
- R11: Each column produces exactly NCELL results. They are marked by `out_valid` on consecutive cycles, start at cell 0 and rise by one per result on `out_cell`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_guard | input | GUARD_W | Guard cells on each side of the cell under test |
| cfg_train | input | TRAIN_W | Training cells on each side (0 is handled as 1) |
| cfg_alpha | input | 8 | Threshold gain, unsigned, 4 fraction bits |
| cfg_mode | input | 2 | 0 cell averaging, 1 greatest-of, 2 smallest-of, 3 cell averaging |
| in_valid | input | 1 | Sample offered |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| busy | output | 1 | Scan in progress; input samples are not accepted |
| out_valid | output | 1 | Result strobe |
| out_cell | output | $clog2(NCELL) | Range index of the result |
| out_detect | output | 1 | Detection flag |
| out_mag | output | 17 | L1 magnitude of the cell |
| out_thr | output | 17 | Threshold applied to the cell |

## Verification
The bench builds the block with NCELL = 16, GUARD_W = 4 and TRAIN_W = 5. A 16-cell column is short enough that every cell of every column checked lies near an edge for guard and train values up to 15 and 8. This drives the shrinking windows, the one-sided and empty-sided fallbacks of greatest-of and smallest-of, and zero thresholds. The sweep covers all four mode codes, guards of 0, 1, 2 and 15, trains of 0, 1, 2, 3 and 8, and gains of 0x0C, 0x30 and 0xFF. The gain of 0xFF with full-scale inputs reaches the 17-bit clip. Three data patterns are used: pseudo-random full-range samples, a single spike over a low floor, and repeating extremes that include -32768 and zero-magnitude cells.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

  localparam int DW         = 16;  // I/Q sample width
  localparam int MAG_W      = DW + 1;
  localparam int ALPHA_W    = 8;
  localparam int ALPHA_FRAC = 4;
  localparam int THR_W      = 17;
  localparam int WIDE_W     = 40;  // headroom for gain x noise and cross products
  localparam int NRD        = 5;   // read ports into the column store

  // read-port roles
  localparam int RD_CUT      = 0;
  localparam int RD_FAR_IN   = 1;  // also used by the prefill phase
  localparam int RD_FAR_OUT  = 2;
  localparam int RD_NEAR_IN  = 3;
  localparam int RD_NEAR_OUT = 4;

  typedef enum logic [1:0] {
    MODE_AVG   = 2'd0,
    MODE_MAX   = 2'd1,
    MODE_MIN   = 2'd2,
    MODE_AVG_B = 2'd3
  } cfar_mode_e;

  function automatic logic [MAG_W-1:0] l1_mag(input logic signed [DW-1:0] si,
                                              input logic signed [DW-1:0] sq);
    logic [DW-1:0] ai, aq;
    ai = si[DW-1] ? (~si + 1'b1) : si;
    aq = sq[DW-1] ? (~sq + 1'b1) : sq;
    return {1'b0, ai} + {1'b0, aq};
  endfunction

  function automatic logic [WIDE_W-1:0] pick_noise(input cfar_mode_e m,
                                                   input logic [WIDE_W-1:0] ns,
                                                   input logic [WIDE_W-1:0] nc,
                                                   input logic [WIDE_W-1:0] fs,
                                                   input logic [WIDE_W-1:0] fc);
    logic [WIDE_W-1:0] near_x, far_x;
    logic near_wins;
    near_x = ns * fc;
    far_x  = fs * nc;
    near_wins = (m == MODE_MAX) ? (near_x > far_x) : (near_x < far_x);
    if (m == MODE_MAX || m == MODE_MIN) begin
      if (nc != '0 && fc != '0) return near_wins ? ns : fs;
      else if (nc != '0)        return ns;
      else                      return fs;
    end
    return ns + fs;
  endfunction

  function automatic logic [THR_W-1:0] scale_thr(input logic [ALPHA_W-1:0] a,
                                                 input logic [WIDE_W-1:0] n);
    logic [WIDE_W-1:0] prod;
    prod = (WIDE_W'(a) * n) >> ALPHA_FRAC;
    if (prod > WIDE_W'((1 << THR_W) - 1)) return THR_W'((1 << THR_W) - 1);
    return prod[THR_W-1:0];
  endfunction

endpackage

// File: rtl/cfar_colbuf.sv
module cfar_colbuf
  import cfar_pkg::*;
#(
  parameter int NCELL = 512,
  parameter int AW    = $clog2(NCELL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy_i,
  input  logic                    in_valid,
  input  logic signed [DW-1:0]    in_i,
  input  logic signed [DW-1:0]    in_q,
  output logic                    col_done,
  input  logic [AW-1:0]           rd_addr [NRD],
  output logic [MAG_W-1:0]        rd_data [NRD]
);

  logic [MAG_W-1:0] mem [NCELL];
  logic [AW-1:0]    wr_ptr;
  logic             accept;
  logic             last_slot;

  assign accept    = in_valid && !busy_i;
  assign last_slot = (wr_ptr == AW'(NCELL - 1));
  assign col_done  = accept && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (accept) begin
      wr_ptr <= last_slot ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= l1_mag(in_i, in_q);
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end

endmodule

// File: rtl/cfar_slide.sv
module cfar_slide
  import cfar_pkg::*;
#(
  parameter int NCELL   = 512,
  parameter int AW      = $clog2(NCELL),
  parameter int GUARD_W = 4,
  parameter int TRAIN_W = 5,
  parameter int SUM_W   = MAG_W + TRAIN_W + 1,
  parameter int CNT_W   = TRAIN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 col_done,
  input  logic [GUARD_W-1:0]   cfg_guard,
  input  logic [TRAIN_W-1:0]   cfg_train,
  input  logic [ALPHA_W-1:0]   cfg_alpha,
  input  logic [1:0]           cfg_mode,
  input  logic [MAG_W-1:0]     rd_data [NRD],
  output logic [AW-1:0]        rd_addr [NRD],
  output logic                 busy,
  output logic                 scan_fire,
  output logic [AW-1:0]        scan_cut,
  output logic [MAG_W-1:0]     cut_mag,
  output logic [SUM_W-1:0]     near_sum,
  output logic [CNT_W-1:0]     near_cnt,
  output logic [SUM_W-1:0]     far_sum,
  output logic [CNT_W-1:0]     far_cnt,
  output logic [TRAIN_W-1:0]   train_q,
  output logic [ALPHA_W-1:0]   alpha_q,
  output cfar_mode_e           mode_q
);

  typedef enum logic [1:0] {ST_FILL, ST_PRE, ST_SCAN} sl_state_e;

  sl_state_e          state;
  logic [GUARD_W-1:0] guard_q;
  logic [TRAIN_W-1:0] k_q;
  logic [AW-1:0]      cut_q;
  int                 ix [NRD];
  logic               hit [NRD];
  logic [SUM_W-1:0]   ext [NRD];

  always_comb begin
    for (int p = 0; p < NRD; p++) ix[p] = 0;
    ix[RD_CUT] = int'(cut_q);
    if (state == ST_PRE) ix[RD_FAR_IN] = int'(guard_q) + 1 + int'(k_q);
    else                 ix[RD_FAR_IN] = int'(cut_q) + int'(guard_q) + 1 + int'(train_q);
    ix[RD_FAR_OUT]  = int'(cut_q) + int'(guard_q) + 1;
    ix[RD_NEAR_IN]  = int'(cut_q) - int'(guard_q);
    ix[RD_NEAR_OUT] = int'(cut_q) - int'(guard_q) - int'(train_q);
    for (int p = 0; p < NRD; p++) begin
      hit[p]     = (ix[p] >= 0) && (ix[p] < NCELL);
      rd_addr[p] = hit[p] ? AW'(ix[p]) : '0;
      ext[p]     = hit[p] ? SUM_W'(rd_data[p]) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      guard_q  <= '0;
      train_q  <= TRAIN_W'(1);
      alpha_q  <= '0;
      mode_q   <= MODE_AVG;
      k_q      <= '0;
      cut_q    <= '0;
      near_sum <= '0;
      near_cnt <= '0;
      far_sum  <= '0;
      far_cnt  <= '0;
    end else begin
      case (state)
        ST_FILL: if (col_done) begin
          guard_q  <= cfg_guard;
          train_q  <= (cfg_train == '0) ? TRAIN_W'(1) : cfg_train;
          alpha_q  <= cfg_alpha;
          mode_q   <= cfar_mode_e'(cfg_mode);
          k_q      <= '0;
          cut_q    <= '0;
          near_sum <= '0;
          near_cnt <= '0;
          far_sum  <= '0;
          far_cnt  <= '0;
          state    <= ST_PRE;
        end
        ST_PRE: begin
          far_sum <= far_sum + ext[RD_FAR_IN];
          far_cnt <= far_cnt + CNT_W'(hit[RD_FAR_IN]);
          k_q     <= k_q + 1'b1;
          if (k_q == train_q - 1'b1) state <= ST_SCAN;
        end
        ST_SCAN: begin
          near_sum <= near_sum + ext[RD_NEAR_IN] - ext[RD_NEAR_OUT];
          near_cnt <= near_cnt + CNT_W'(hit[RD_NEAR_IN]) - CNT_W'(hit[RD_NEAR_OUT]);
          far_sum  <= far_sum + ext[RD_FAR_IN] - ext[RD_FAR_OUT];
          far_cnt  <= far_cnt + CNT_W'(hit[RD_FAR_IN]) - CNT_W'(hit[RD_FAR_OUT]);
          cut_q    <= cut_q + 1'b1;
          if (cut_q == AW'(NCELL - 1)) state <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  assign busy      = (state != ST_FILL);
  assign scan_fire = (state == ST_SCAN);
  assign scan_cut  = cut_q;
  assign cut_mag   = rd_data[RD_CUT];

endmodule

// File: rtl/cfar_decide.sv
module cfar_decide
  import cfar_pkg::*;
#(
  parameter int AW    = 9,
  parameter int SUM_W = 23,
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [AW-1:0]      cut,
  input  logic [MAG_W-1:0]   cut_mag,
  input  logic [SUM_W-1:0]   near_sum,
  input  logic [CNT_W-1:0]   near_cnt,
  input  logic [SUM_W-1:0]   far_sum,
  input  logic [CNT_W-1:0]   far_cnt,
  input  logic [ALPHA_W-1:0] alpha,
  input  cfar_mode_e         mode,
  output logic [WIDE_W-1:0]  noise_now,
  output logic [THR_W-1:0]   thr_now,
  output logic               out_valid,
  output logic [AW-1:0]      out_cell,
  output logic               out_detect,
  output logic [MAG_W-1:0]   out_mag,
  output logic [THR_W-1:0]   out_thr
);

  logic det_now;

  assign noise_now = pick_noise(mode, WIDE_W'(near_sum), WIDE_W'(near_cnt),
                                WIDE_W'(far_sum), WIDE_W'(far_cnt));
  assign thr_now   = scale_thr(alpha, noise_now);
  assign det_now   = (cut_mag > thr_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_cell   <= '0;
      out_detect <= 1'b0;
      out_mag    <= '0;
      out_thr    <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_cell   <= cut;
        out_detect <= det_now;
        out_mag    <= cut_mag;
        out_thr    <= thr_now;
      end
    end
  end

endmodule

// File: rtl/cfar_detector.sv
module cfar_detector
  import cfar_pkg::*;
#(
  parameter int NCELL   = 512,
  parameter int GUARD_W = 4,
  parameter int TRAIN_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [GUARD_W-1:0]         cfg_guard,
  input  logic [TRAIN_W-1:0]         cfg_train,
  input  logic [7:0]                 cfg_alpha,
  input  logic [1:0]                 cfg_mode,
  input  logic                       in_valid,
  input  logic signed [15:0]         in_i,
  input  logic signed [15:0]         in_q,
  output logic                       busy,
  output logic                       out_valid,
  output logic [$clog2(NCELL)-1:0]   out_cell,
  output logic                       out_detect,
  output logic [16:0]                out_mag,
  output logic [16:0]                out_thr
);

  localparam int AW    = $clog2(NCELL);
  localparam int CNT_W = TRAIN_W + 1;
  localparam int SUM_W = MAG_W + TRAIN_W + 1;

  logic               col_done;
  logic [AW-1:0]      rd_addr [NRD];
  logic [MAG_W-1:0]   rd_data [NRD];
  logic               scan_fire;
  logic [AW-1:0]      scan_cut;
  logic [MAG_W-1:0]   cut_mag;
  logic [SUM_W-1:0]   near_sum, far_sum;
  logic [CNT_W-1:0]   near_cnt, far_cnt;
  logic [TRAIN_W-1:0] train_q;
  logic [ALPHA_W-1:0] alpha_q;
  cfar_mode_e         mode_q;
  logic [WIDE_W-1:0]  noise_now;
  logic [THR_W-1:0]   thr_now;

  cfar_colbuf #(.NCELL(NCELL), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .col_done(col_done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfar_slide #(.NCELL(NCELL), .AW(AW), .GUARD_W(GUARD_W), .TRAIN_W(TRAIN_W),
               .SUM_W(SUM_W), .CNT_W(CNT_W)) u_slide (
    .clk(clk), .rst_n(rst_n), .col_done(col_done),
    .cfg_guard(cfg_guard), .cfg_train(cfg_train), .cfg_alpha(cfg_alpha),
    .cfg_mode(cfg_mode), .rd_data(rd_data), .rd_addr(rd_addr), .busy(busy),
    .scan_fire(scan_fire), .scan_cut(scan_cut), .cut_mag(cut_mag),
    .near_sum(near_sum), .near_cnt(near_cnt), .far_sum(far_sum),
    .far_cnt(far_cnt), .train_q(train_q), .alpha_q(alpha_q), .mode_q(mode_q)
  );

  cfar_decide #(.AW(AW), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(scan_fire), .cut(scan_cut),
    .cut_mag(cut_mag), .near_sum(near_sum), .near_cnt(near_cnt),
    .far_sum(far_sum), .far_cnt(far_cnt), .alpha(alpha_q), .mode(mode_q),
    .noise_now(noise_now), .thr_now(thr_now), .out_valid(out_valid),
    .out_cell(out_cell), .out_detect(out_detect), .out_mag(out_mag),
    .out_thr(out_thr)
  );

endmodule

// File: rtl/cfar_checker.sv
module cfar_checker #(
  parameter int NCELL   = 512,
  parameter int AW      = 9,
  parameter int TRAIN_W = 5,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               out_valid,
  input logic [AW-1:0]      out_cell,
  input logic               out_detect,
  input logic [16:0]        out_mag,
  input logic [16:0]        out_thr,
  input logic [CNT_W-1:0]   near_cnt,
  input logic [CNT_W-1:0]   far_cnt,
  input logic [TRAIN_W-1:0] train_q
);

  assert_cells_ascend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_cell == AW'($past(out_cell) + 1'b1));

  assert_first_cell_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_cell == '0);

  assert_busy_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_cell != AW'(NCELL - 1)) |-> busy);

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (near_cnt <= CNT_W'(train_q)) && (far_cnt <= CNT_W'(train_q)));

  assert_train_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> train_q != '0);

  assert_strict_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_detect == (out_mag > out_thr));

endmodule

bind cfar_detector cfar_checker #(
  .NCELL(NCELL), .AW(AW), .TRAIN_W(TRAIN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_cell(out_cell), .out_detect(out_detect), .out_mag(out_mag),
  .out_thr(out_thr), .near_cnt(near_cnt), .far_cnt(far_cnt),
  .train_q(train_q)
);

// File: tb/tb_cfar_detector.sv
`timescale 1ns/1ps
module tb_cfar_detector;

  localparam int N  = 16;
  localparam int GW = 4;
  localparam int TW = 5;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [GW-1:0] cfg_guard = '0;
  logic [TW-1:0] cfg_train = '0;
  logic [7:0] cfg_alpha = '0;
  logic [1:0] cfg_mode = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic busy, out_valid, out_detect;
  logic [AW-1:0] out_cell;
  logic [16:0] out_mag, out_thr;

  always #2 clk = ~clk;  // 250 MHz

  cfar_detector #(.NCELL(N), .GUARD_W(GW), .TRAIN_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_guard(cfg_guard), .cfg_train(cfg_train),
    .cfg_alpha(cfg_alpha), .cfg_mode(cfg_mode), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .busy(busy), .out_valid(out_valid),
    .out_cell(out_cell), .out_detect(out_detect), .out_mag(out_mag),
    .out_thr(out_thr)
  );

  int tests = 0;
  int fails = 0;
  int rx = 0;
  bit finished = 0;
  int di [N];
  int dq [N];
  longint emag [N];
  longint ethr [N];
  bit edet [N];
  string etag = "R3";
  int unsigned lcg = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint ref_mag(input int vi, input int vq);
    longint ai, aq;
    ai = (vi < 0) ? ((-vi) & 16'hFFFF) : vi;
    aq = (vq < 0) ? ((-vq) & 16'hFFFF) : vq;
    return ai + aq;
  endfunction

  function automatic int next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg >> 16);
  endfunction

  task automatic build_expect(input int g, input int t, input int a, input int m);
    int tt;
    tt = (t == 0) ? 1 : t;
    for (int c = 0; c < N; c++) emag[c] = ref_mag(di[c], dq[c]);
    for (int c = 0; c < N; c++) begin
      longint ls, lc, rs, rc, noise, raw;
      ls = 0; lc = 0; rs = 0; rc = 0;
      for (int k = 1; k <= tt; k++) begin
        if (c - g - k >= 0) begin ls += emag[c - g - k]; lc++; end
        if (c + g + k < N)  begin rs += emag[c + g + k]; rc++; end
      end
      if (m == 1 || m == 2) begin
        if (lc > 0 && rc > 0) begin
          if (m == 1) noise = (ls * rc > rs * lc) ? ls : rs;
          else        noise = (ls * rc < rs * lc) ? ls : rs;
        end else if (lc > 0) noise = ls;
        else noise = rs;
      end else begin
        noise = ls + rs;
      end
      raw = (longint'(a) * noise) / 16;
      ethr[c] = (raw > 131071) ? 131071 : raw;
      edet[c] = emag[c] > ethr[c];
    end
  endtask

  // result collector, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rx >= N) begin
        check(1'b0, "R11", "result beyond column length", rx, N);
      end else begin
        check(out_cell == AW'(rx), "R11", "cell index order", out_cell, rx);
        check(out_mag == 17'(emag[rx]), "R1", "magnitude", out_mag, emag[rx]);
        check(out_thr == 17'(ethr[rx]), etag, "threshold", out_thr, ethr[rx]);
        check(out_detect == edet[rx], "R7", "detect flag", out_detect, edet[rx]);
      end
      rx++;
    end
  end

  task automatic send_column(input int g, input int t, input int a,
                             input int m, input int col);
    string mtag;
    for (int c = 0; c < N; c++) begin
      case (col % 3)
        0: begin di[c] = next_rand() - 32768; dq[c] = next_rand() - 32768; end
        1: begin
          di[c] = (next_rand() & 63) - 32; dq[c] = (next_rand() & 63) - 32;
          if (c == (col % N)) begin di[c] = 20000; dq[c] = -15000; end
        end
        default: case (c % 4)
          0: begin di[c] = -32768; dq[c] = -32768; end
          1: begin di[c] = 32767;  dq[c] = 32767;  end
          2: begin di[c] = 0;      dq[c] = 0;      end
          default: begin di[c] = -1; dq[c] = 1;    end
        endcase
      endcase
    end
    build_expect(g, t, a, m);
    mtag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R8";
    etag = $sformatf("R2 R6 %s%s", mtag, (t == 0) ? " R9" : "");
    rx = 0;
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      cfg_guard = GW'(g); cfg_train = TW'(t); cfg_alpha = 8'(a); cfg_mode = 2'(m);
      in_valid = 1'b1; in_i = 16'(di[c]); in_q = 16'(dq[c]);
    end
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy after last sample", busy, 1);
    // configuration churn and samples offered during the scan must be ignored
    cfg_guard = '1; cfg_train = '1; cfg_alpha = 8'h01; cfg_mode = ~2'(m);
    for (int k = 0; k < 3; k++) begin
      in_i = 16'sh7FFF; in_q = -16'sd7;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait (rx >= N);
    @(negedge clk);
    @(negedge clk);
    check(rx == N, "R11", "results per column", rx, N);
    check(busy == 1'b0, "R10", "busy after scan", busy, 0);
  endtask

  initial begin
    int guards [4] = '{0, 1, 2, 15};
    int trains [5] = '{0, 1, 2, 3, 8};
    int alphas [3] = '{8'h30, 8'h0C, 8'hFF};
    int col;
    col = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(busy == 1'b0, "R10", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    for (int m = 0; m < 4; m++)
      for (int gi = 0; gi < 4; gi++)
        for (int ti = 0; ti < 5; ti++)
          for (int ai = 0; ai < 3; ai++) begin
            send_column(guards[gi], trains[ti], alphas[ai], m, col);
            col++;
          end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule